// File: doc/BRIEF.md
# I2C Serial EEPROM Target Controller

This block is an I2C target that serves a 2048-byte store held inside the chip. It oversamples the bus clock and data lines with the system clock. It detects start and stop conditions from those samples. It then walks through the address byte, the word address and the data bytes, and it answers on the data line through an open-drain pull-down enable. The address byte has three parts: a fixed four-bit type code, three block bits that become the top of the memory address, and a direction bit.

Writes go into a page buffer of 32 entries. Each entry carries its own valid flag. The buffer is copied into the store only when the transfer ends with a stop. After that stop the target spends a programmable number of clock cycles busy, and during that time it refuses its address. Reads stream bytes from an internal pointer that advances through the whole address space. A host sets up a random read by writing a word address and then issuing a repeated start with the read bit set.

Top module: `eep_i2c_target`

## Requirements
- R1: After reset, and whenever no transfer is addressed to the target, `sda_oe` is 0, so the data line is released.
- R2: The target acknowledges an address byte only when bits 7:4 equal 4'b1010. For any other value it does not acknowledge that byte, nor any later byte, until the next START.
- R3: Address-byte bits 3:1 form memory address bits 10:8. In a write, the byte after the address byte is acknowledged and becomes address bits 7:0.
- R4: Every write data byte is acknowledged. After each one, address bits 4:0 increment and wrap within the 32-byte page, while bits 10:5 stay fixed. When a byte lands on an offset already written in the same transfer, the later byte replaces the earlier one.
- R5: Written bytes are not placed in the store before STOP. A read issued after a repeated START in the same transfer returns the old contents. The STOP then commits every buffered byte.
- R6: After a STOP that ends a write carrying at least one data byte, the address byte is not acknowledged for BUSY_CYCLES clock cycles. It is acknowledged again once that window has passed.
- R7: Address-byte bit 0 set to 1 selects a read. The target returns the byte at address {address-byte bits 3:1, pointer bits 7:0}, most significant bit first, and changes the data line only while the bus clock is low.
- R8: When the host acknowledges a read byte, the next byte comes from the pointer plus one. The pointer wraps from 2047 to 0.
- R9: When the host does not acknowledge a read byte, the target releases the data line and stays released for further clocks until a START.
- R10: An acknowledge from the target holds the data line low for the whole high phase of the ninth clock. The line is released after that clock falls.
- R11: A START in the middle of a byte drops the partial byte, and address decoding begins again.
- R12: A write that carries only a word address and then a STOP does not start the busy window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong decode state most often shows up as a missing or extra acknowledge on the ninth clock of the byte it affects, so one byte time exposes it. A fault in the page buffer or the commit walk does not appear during the write itself. It appears only when the data is read back after the busy window, so the write-then-read pairs cross page wraps, block bits, and the top end of the address space. A busy counter that runs too long or too short changes whether the first address after a stop is acknowledged, and that is visible within a single probe.

// File: rtl/eep_pkg.sv
// Shared types and constants for the serial EEPROM target.
// Assumes an 11-bit store address: 3 block bits plus an 8-bit word address.
package eep_pkg;
    localparam logic [3:0] DEV_TYPE_ID = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } eep_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_WADDR,
        K_WDATA
    } eep_kind_e;
endpackage

// File: rtl/eep_bus_sync.sv
// Brings SCL and SDA into the clock domain through two flops each, then
// flags clock edges and START/STOP conditions. Assumes clk runs several
// times faster than SCL. Idle value of both lines is high.
module eep_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_m, sda_m, scl_p, sda_p;

    // Two-stage synchroniser plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            sda_m <= 1'b1;
            scl_s <= 1'b1;
            sda_s <= 1'b1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_m <= scl_i;
            sda_m <= sda_i;
            scl_s <= scl_m;
            sda_s <= sda_m;
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Edge and bus-condition decode on the synchronised samples.
    always_comb begin
        scl_rise = scl_s & ~scl_p;
        scl_fall = ~scl_s & scl_p;
        start_ev = scl_s & scl_p & sda_p & ~sda_s;
        stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/eep_page_buf.sv
// Page staging buffer: one data byte and one valid flag per page offset.
// On commit_go it latches the page tag and walks every offset once, one per
// clock, emitting a store write for each valid entry and clearing it.
// Assumes no new writes arrive while a commit walk is running.
module eep_page_buf #(
    parameter int PAGE_BYTES = 32,
    parameter int AW         = 11,
    localparam int IW        = $clog2(PAGE_BYTES),
    localparam int TW        = AW - IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          commit_go,
    input  logic [TW-1:0] commit_tag,
    output logic          pending,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data
);
    logic [7:0]            ent_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] ent_valid;
    logic                  running;
    logic [IW-1:0]         cidx;
    logic [TW-1:0]         ctag;

    // Entry storage: capture incoming bytes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (wr_en && wr_idx == IW'(i)) ent_data[i] <= wr_data;
        end
    end

    // Valid flags: set on capture, cleared as the commit walk passes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
        end else begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (wr_en && wr_idx == IW'(i)) ent_valid[i] <= 1'b1;
                else if (running && cidx == IW'(i)) ent_valid[i] <= 1'b0;
            end
        end
    end

    // Commit walk sequencer over all page offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cidx    <= '0;
            ctag    <= '0;
        end else if (commit_go) begin
            running <= 1'b1;
            cidx    <= '0;
            ctag    <= commit_tag;
        end else if (running) begin
            cidx <= cidx + 1'b1;
            if (cidx == IW'(PAGE_BYTES - 1)) running <= 1'b0;
        end
    end

    // Store write port and pending indication.
    always_comb begin
        pending  = |ent_valid;
        mem_we   = running && ent_valid[cidx];
        mem_addr = {ctag, cidx};
        mem_data = ent_data[cidx];
    end
endmodule

// File: rtl/eep_store.sv
// Byte store with one write port and a registered read port.
// Contents are not reset; only the read register is.
module eep_store #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Array write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read, refreshed every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end
endmodule

// File: rtl/eep_i2c_target.sv
// I2C target fronting a byte store. Decodes the address byte (type code,
// block bits, direction), takes a word address, stages written bytes in a
// page buffer committed at STOP, then holds a busy window. Reads stream from
// an 11-bit pointer. Assumes clk is at least 8x the SCL rate and that the
// store address is 3 block bits plus 8 word bits.
module eep_i2c_target #(
    parameter int MEM_BYTES   = 2048,
    parameter int PAGE_BYTES  = 32,
    parameter int BUSY_CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import eep_pkg::*;

    localparam int AW    = $clog2(MEM_BYTES);
    localparam int IW    = $clog2(PAGE_BYTES);
    localparam int TW    = AW - IW;
    localparam int BLK_W = AW - 8;
    localparam int BCW   = $clog2(BUSY_CYCLES + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    eep_state_e       st;
    eep_kind_e        kind;
    logic [3:0]       bitcnt;
    logic [7:0]       shreg;
    logic [7:0]       txsh;
    logic [BLK_W-1:0] blk;
    logic             rw;
    logic             mack;
    logic [AW-1:0]    ptr;
    logic [TW-1:0]    tag;
    logic [AW-1:0]    waddr_full;
    logic             pb_we;
    logic [IW-1:0]    pb_idx;
    logic [7:0]       pb_data;
    logic             pending, commit_go;
    logic             mem_we;
    logic [AW-1:0]    mem_addr;
    logic [7:0]       mem_data, rd_q;
    logic [BCW-1:0]   busy_cnt;
    logic             busy;

    eep_bus_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    eep_page_buf #(.PAGE_BYTES(PAGE_BYTES), .AW(AW)) u_page (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (pb_we),
        .wr_idx     (pb_idx),
        .wr_data    (pb_data),
        .commit_go  (commit_go),
        .commit_tag (tag),
        .pending    (pending),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data)
    );

    eep_store #(.DEPTH(MEM_BYTES)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_data),
        .raddr (ptr),
        .rdata (rd_q)
    );

    // Full word address formed from the latched block bits and the received byte.
    always_comb begin
        waddr_full = {blk, shreg};
        commit_go  = stop_ev && pending;
        busy       = (busy_cnt != '0);
    end

    // Busy window: loaded by a committing STOP, then counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_cnt <= '0;
        else if (commit_go) busy_cnt <= BCW'(BUSY_CYCLES);
        else if (busy)      busy_cnt <= busy_cnt - 1'b1;
    end

    // Protocol sequencer: bit shifting, acknowledge and transmit control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            kind    <= K_DEV;
            bitcnt  <= '0;
            shreg   <= '0;
            txsh    <= '0;
            blk     <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            ptr     <= '0;
            tag     <= '0;
            sda_oe  <= 1'b0;
            pb_we   <= 1'b0;
            pb_idx  <= '0;
            pb_data <= '0;
        end else begin
            pb_we <= 1'b0;
            if (start_ev) begin
                st     <= ST_RX;
                kind   <= K_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_ev) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            case (kind)
                                K_DEV: begin
                                    if (shreg[7:4] == DEV_TYPE_ID && !busy) begin
                                        blk    <= shreg[BLK_W:1];
                                        rw     <= shreg[0];
                                        if (shreg[0]) ptr[AW-1:8] <= shreg[BLK_W:1];
                                        sda_oe <= 1'b1;
                                        st     <= ST_ACK;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                K_WADDR: begin
                                    ptr    <= waddr_full;
                                    tag    <= waddr_full[AW-1:IW];
                                    sda_oe <= 1'b1;
                                    st     <= ST_ACK;
                                end
                                default: begin
                                    pb_we   <= 1'b1;
                                    pb_idx  <= ptr[IW-1:0];
                                    pb_data <= shreg;
                                    ptr     <= {ptr[AW-1:IW], ptr[IW-1:0] + 1'b1};
                                    sda_oe  <= 1'b1;
                                    st      <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (kind == K_DEV && rw) begin
                                st     <= ST_TX;
                                txsh   <= rd_q;
                                sda_oe <= ~rd_q[7];
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_RX;
                                kind   <= (kind == K_DEV) ? K_WADDR : K_WDATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                st     <= ST_MACK;
                                ptr    <= ptr + 1'b1;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                                txsh   <= {txsh[6:0], 1'b0};
                                sda_oe <= ~txsh[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                st     <= ST_TX;
                                bitcnt <= '0;
                                txsh   <= rd_q;
                                sda_oe <= ~rd_q[7];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eep_checker.sv
// Protocol checker bound into the EEPROM target. Observes sequencer state,
// the synchronised clock line, the busy window and the store write strobe.
module eep_checker (
    input logic                clk,
    input logic                rst_n,
    input eep_pkg::eep_state_e st,
    input eep_pkg::eep_kind_e  kind,
    input logic                scl_s,
    input logic                sda_oe,
    input logic                busy,
    input logic                mem_we
);
    import eep_pkg::*;

    // R1: no pull-down while idle
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    // R10: acknowledge held through the high phase
    a_r10_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK && scl_s) |-> sda_oe);

    // R7: transmit data changes only with the clock low
    a_r7_tx_change_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TX && !$stable(sda_oe)) |-> !scl_s);

    // R6: no address acknowledge inside the busy window
    a_r6_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK && kind == K_DEV) |-> !busy);

    // R5: store is written only during the post-STOP window
    a_r5_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
endmodule

bind eep_i2c_target eep_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .st     (st),
    .kind   (kind),
    .scl_s  (scl_s),
    .sda_oe (sda_oe),
    .busy   (busy),
    .mem_we (mem_we)
);

// File: tb/sim_eep_i2c_target.sv
// Scoreboard bench: the bus-master tasks push expected acks and read bytes,
// the bus tasks push observed values, and a monitor pairs and compares them.
module sim_eep_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;
    localparam int BUSY       = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    wire  sda_line = ~(sda_oe | m_low);

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int    exp_q [$];
    string tag_q [$];
    int    act_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eep_i2c_target #(.MEM_BYTES(2048), .PAGE_BYTES(32), .BUSY_CYCLES(BUSY)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    task automatic chk(input bit ok, input string t, input int a, input int e);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", t, a, e);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wt(H);
        m_scl = 1'b1; wt(H);
        m_low = 1'b1; wt(H);
        m_scl = 1'b0; wt(2);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wt(H);
        m_scl = 1'b1; wt(H);
        m_low = 1'b0; wt(H);
    endtask

    task automatic bit_out(input bit b);
        m_low = ~b; wt(H);
        m_scl = 1'b1; wt(H);
        m_scl = 1'b0; wt(2);
    endtask

    // Driver: send a byte, expecting ack value (0 = ack, 1 = no ack).
    task automatic wb(input logic [7:0] b, input int exp_ack, input string t);
        int lo = 0;
        int hi = 0;
        exp_q.push_back(exp_ack);
        tag_q.push_back(t);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        m_low = 1'b0; wt(H);
        m_scl = 1'b1;
        for (int i = 0; i < H; i++) begin
            @(negedge clk);
            if (sda_line) hi++; else lo++;
        end
        m_scl = 1'b0; wt(2);
        act_q.push_back(hi == 0 ? 0 : (lo == 0 ? 1 : 2));
    endtask

    // Driver: receive a byte, then ack (1) or not (0).
    task automatic rb(input logic [7:0] e, input bit ack_m, input string t);
        logic [7:0] v = '0;
        exp_q.push_back(int'(e));
        tag_q.push_back(t);
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wt(H);
            m_scl = 1'b1; wt(H/2);
            v = {v[6:0], sda_line};
            wt(H - H/2);
            m_scl = 1'b0; wt(2);
        end
        m_low = ack_m; wt(H);
        m_scl = 1'b1; wt(H);
        m_scl = 1'b0; wt(2);
        m_low = 1'b0;
        act_q.push_back(int'(v));
    endtask

    // Monitor: pair observed results with expected items.
    int    mon_a;
    int    mon_e;
    string mon_t;
    always @(negedge clk) begin
        if (act_q.size() > 0) begin
            mon_a = act_q.pop_front();
            if (exp_q.size() == 0) begin
                chk(1'b0, "SCOREBOARD", mon_a, 0);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                chk(mon_a == mon_e, mon_t, mon_a, mon_e);
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        summary();
    end

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        chk(sda_oe == 1'b0 && sda_line == 1'b1, "R1", int'(sda_oe), 0);

        // R2: wrong type code, no ack for it nor the next byte
        bus_start();
        wb(8'h50, 1, "R2");
        wb(8'hA0, 1, "R2");
        chk(sda_oe == 1'b0, "R1", int'(sda_oe), 0);
        bus_stop();

        // R3: block 1, word 0x5E gets 0x77
        bus_start();
        wb(8'hA2, 0, "R3");
        wb(8'h5E, 0, "R3");
        wb(8'h77, 0, "R4");
        bus_stop();
        wt(BUSY + 100);

        // R4 / R10: page write across the page end in block 3
        bus_start();
        wb(8'hA6, 0, "R3");
        wb(8'h5E, 0, "R10");
        wt(4);
        chk(sda_line == 1'b1, "R10", int'(sda_line), 1);
        wb(8'hA0, 0, "R4");
        wb(8'hA1, 0, "R4");
        wb(8'hA2, 0, "R4");
        wb(8'hA3, 0, "R4");
        bus_stop();
        // R6: busy right after the committing STOP
        bus_start();
        wb(8'hA0, 1, "R6");
        bus_stop();
        wt(BUSY + 100);

        // R11: abort mid-byte, then random read at 0x35E
        bus_start();
        wb(8'hA0, 0, "R11");
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_start();
        wb(8'hA6, 0, "R11");
        wb(8'h5E, 0, "R11");
        bus_start();
        wb(8'hA7, 0, "R6");
        rb(8'hA0, 1'b1, "R7");
        rb(8'hA1, 1'b0, "R4");
        // R9: line stays released after no-ack
        m_scl = 1'b1; wt(H);
        chk(sda_line == 1'b1, "R9", int'(sda_line), 1);
        m_scl = 1'b0; wt(H);
        chk(sda_line == 1'b1, "R9", int'(sda_line), 1);
        bus_stop();

        // R4: wrapped bytes landed at offsets 0 and 1 of the page
        bus_start();
        wb(8'hA6, 0, "R4");
        wb(8'h40, 0, "R4");
        bus_start();
        wb(8'hA7, 0, "R4");
        rb(8'hA2, 1'b1, "R4");
        rb(8'hA3, 1'b0, "R4");
        bus_stop();

        // R3: block 1 copy of word 0x5E distinct from block 3
        bus_start();
        wb(8'hA2, 0, "R3");
        wb(8'h5E, 0, "R3");
        bus_start();
        wb(8'hA3, 0, "R3");
        rb(8'h77, 1'b0, "R3");
        bus_stop();

        // R4: 33 bytes into block 5 page at 0x520, last overwrites offset 0
        bus_start();
        wb(8'hAA, 0, "R4");
        wb(8'h20, 0, "R4");
        for (int k = 0; k < 33; k++) wb(8'(8'h10 + k), 0, "R4");
        bus_stop();
        wt(BUSY + 100);
        bus_start();
        wb(8'hAA, 0, "R4");
        wb(8'h20, 0, "R4");
        bus_start();
        wb(8'hAB, 0, "R4");
        rb(8'h30, 1'b1, "R4");
        rb(8'h11, 1'b1, "R4");
        rb(8'h12, 1'b0, "R4");
        bus_stop();

        // R8: pointer wrap from 2047 to 0
        bus_start();
        wb(8'hAE, 0, "R8");
        wb(8'hFF, 0, "R8");
        wb(8'h5A, 0, "R8");
        bus_stop();
        wt(BUSY + 100);
        bus_start();
        wb(8'hA0, 0, "R8");
        wb(8'h00, 0, "R8");
        wb(8'hC3, 0, "R8");
        bus_stop();
        wt(BUSY + 100);
        bus_start();
        wb(8'hAE, 0, "R8");
        wb(8'hFF, 0, "R8");
        bus_start();
        wb(8'hAF, 0, "R8");
        rb(8'h5A, 1'b1, "R8");
        rb(8'hC3, 1'b0, "R8");
        bus_stop();

        // R12: word-address-only write leaves no busy window
        bus_start();
        wb(8'hA0, 0, "R12");
        wb(8'h00, 0, "R12");
        bus_stop();
        bus_start();
        wb(8'hA1, 0, "R12");
        rb(8'hC3, 1'b0, "R12");
        bus_stop();

        // R7: block bits of the read byte pick the upper address bits
        bus_start();
        wb(8'hA0, 0, "R7");
        wb(8'h5F, 0, "R7");
        bus_stop();
        bus_start();
        wb(8'hA7, 0, "R7");
        rb(8'hA1, 1'b0, "R7");
        bus_stop();

        // R5: staged byte invisible before STOP, committed after it
        bus_start();
        wb(8'hA6, 0, "R5");
        wb(8'h5E, 0, "R5");
        wb(8'h99, 0, "R5");
        bus_start();
        wb(8'hA6, 0, "R5");
        wb(8'h5E, 0, "R5");
        bus_start();
        wb(8'hA7, 0, "R5");
        rb(8'hA0, 1'b0, "R5");
        bus_stop();
        bus_start();
        wb(8'hA0, 1, "R6");
        bus_stop();
        wt(BUSY + 100);
        bus_start();
        wb(8'hA6, 0, "R5");
        wb(8'h5E, 0, "R5");
        bus_start();
        wb(8'hA7, 0, "R5");
        rb(8'h99, 1'b0, "R5");
        bus_stop();

        wt(10);
        chk(exp_q.size() == 0, "SCOREBOARD", exp_q.size(), 0);
        summary();
    end
endmodule